// File: doc/BRIEF.md
# PWM ADC Sample Trigger Generator

This block turns a free-running PWM period counter into single-cycle ADC sample-start pulses. On every update-event strobe it computes where in the coming period the samples should land and holds those positions fixed until the next strobe. The counter, the duty-cycle filter and the converter all sit outside the block. The block only computes the positions, holds them and fires the pulses.

Trigger 1 is placed in one of two ways. It can sit at a programmed count. It can also follow the midpoint of the on-time, which is the event-1 position plus half the loop duty plus an offset. The midpoint can be built from the duty value present at the current update event or from the one captured at the previous event. Up to three extra trigger-1 pulses can be added per period, at one half, one quarter and one eighth of the programmed trigger value. Trigger 2 is a plain compare against its own value, which is also latched on the update event. A small control register holds the two enables, the placement mode and the oversample depth.

Top module: `sample_trig_gen`

## Requirements
- R1: After reset, `trig1_o` and `trig2_o` are low. The control register holds {t1_en=1, t2_en=0, mode=00, os=00}. Its layout is `ctl_wdata_i[5]`=t1_en, `[4]`=t2_en, `[3:2]`=mode, `[1:0]`=os, and it is written when `ctl_we_i` is high. No pulse of either kind occurs before the first update event.
- R2: In mode 00, the base trigger-1 position is `prog_trig_i`.
- R3: Mode 01 places the base position at `ev1_i + duty_i/2 + adapt_ofs_i`, using the duty value present at the update event. Mode 11 uses the same duty value but adds `fixed_ofs_i` in place of the adaptive offset. Both offsets are two's-complement values.
- R4: Mode 10 uses the midpoint formula with the duty value captured at the previous update event. Before any update event, that captured duty value is 0.
- R5: The oversample field os adds trigger-1 positions at `prog_trig_i>>1` when os≥1, at `>>2` when os≥2, and at `>>3` when os=3. The base position is always active.
- R6: When several active trigger-1 positions are equal, exactly one pulse is produced for that count.
- R7: A midpoint sum above 2^CNT_W-1 saturates to 2^CNT_W-1. A negative sum clamps to 0.
- R8: All positions, the oversample depth, the trigger-2 compare value and the previous-duty register change only on a cycle where `upd_i` is high.
- R9: Each pulse is one clock wide and appears in the cycle after the one in which `cnt_i` equals an active position.
- R10: `trig1_o` and `trig2_o` are gated by their enables, and each enable is sampled in the same cycle as the compare.
- R11: `trig2_o` pulses when `cnt_i` equals the compare value that was latched from `trig2_cmp_i` at the last update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | PWM period counter |
| upd_i | input | 1 | Update-event strobe |
| ev1_i | input | CNT_W | Event-1 position |
| duty_i | input | CNT_W | Loop duty value |
| adapt_ofs_i | input | OFS_W | Signed adaptive offset |
| fixed_ofs_i | input | OFS_W | Signed fixed offset (mode 11) |
| prog_trig_i | input | CNT_W | Programmed sample-trigger value |
| trig2_cmp_i | input | CNT_W | Trigger-2 compare value |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 6 | Control write data |
| trig1_o | output | 1 | Trigger-1 sample pulse |
| trig2_o | output | 1 | Trigger-2 sample pulse |

## Verification
A wrong latched position shows as a pulse at the wrong count, or as a missing pulse, during the sweep of the counter that follows the next update event. Wrong saturation or clamping shows as a pulse at a wrapped count, or no pulse near the top of the range. An error in the previous-duty register appears only in mode 10, one update event late. The bench therefore applies two update events per vector with different duty values. An enable or arming error shows within a single sweep as pulses that should not be there.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int OS_N = 4;
  localparam int OS_W = 2;

  typedef enum logic [1:0] {
    MODE_FIXED      = 2'b00,
    MODE_MID_CUR    = 2'b01,
    MODE_MID_PREV   = 2'b10,
    MODE_MID_FIXOFS = 2'b11
  } mode_e;

  typedef struct packed {
    logic            t1_en;
    logic            t2_en;
    mode_e           mode;
    logic [OS_W-1:0] os;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{t1_en: 1'b1, t2_en: 1'b0, mode: MODE_FIXED, os: '0};
endpackage

// File: rtl/stg_ctl_reg.sv
module stg_ctl_reg
  import stg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we_i,
  input  logic [5:0] wdata_i,
  output ctl_t       ctl_o
);
  always_ff @(posedge clk) begin
    if (rst) ctl_o <= CTL_RESET;
    else if (we_i) ctl_o <= ctl_t'(wdata_i);
  end

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(ctl_o)); // R1
endmodule

// File: rtl/stg_pos_calc.sv
module stg_pos_calc
  import stg_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int OFS_W = 14
) (
  input  logic                          clk,
  input  logic                          rst,
  input  mode_e                         mode_i,
  input  logic [OS_W-1:0]               os_i,
  input  logic [CNT_W-1:0]              ev1_i,
  input  logic [CNT_W-1:0]              duty_i,
  input  logic [CNT_W-1:0]              prev_duty_i,
  input  logic signed [OFS_W-1:0]       adapt_ofs_i,
  input  logic signed [OFS_W-1:0]       fixed_ofs_i,
  input  logic [CNT_W-1:0]              prog_i,
  output logic [OS_N-1:0][CNT_W-1:0]    pos_o,
  output logic [OS_N-1:0]               mask_o
);
  localparam int SW = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 2;
  localparam logic signed [SW-1:0] MAXV = signed'({{(SW-CNT_W){1'b0}}, {CNT_W{1'b1}}});

  logic [CNT_W-1:0]        duty_sel;
  logic signed [OFS_W-1:0] ofs_sel;
  logic signed [SW-1:0]    ev_s, half_s, ofs_s, sum_s;
  logic [CNT_W-1:0]        mid;

  always_comb begin
    duty_sel = (mode_i == MODE_MID_PREV) ? prev_duty_i : duty_i;
    ofs_sel  = (mode_i == MODE_MID_FIXOFS) ? fixed_ofs_i : adapt_ofs_i;
    ev_s     = signed'(SW'(ev1_i));
    half_s   = signed'(SW'(duty_sel >> 1));
    ofs_s    = SW'(ofs_sel);
    sum_s    = ev_s + half_s + ofs_s;
    if (sum_s < 0)         mid = '0;
    else if (sum_s > MAXV) mid = '1;
    else                   mid = sum_s[CNT_W-1:0];
  end

  assign pos_o[0]  = (mode_i == MODE_FIXED) ? prog_i : mid;
  assign mask_o[0] = 1'b1;

  for (genvar k = 1; k < OS_N; k++) begin : g_os
    assign pos_o[k]  = prog_i >> k;
    assign mask_o[k] = (os_i >= OS_W'(k));
  end

  AST_MID_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !ofs_sel[OFS_W-1] |-> (mid >= ev1_i)); // R7
endmodule

// File: rtl/stg_pos_latch.sv
module stg_pos_latch
  import stg_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       upd_i,
  input  logic [CNT_W-1:0]           duty_i,
  input  logic [OS_W-1:0]            os_i,
  input  logic [OS_N-1:0][CNT_W-1:0] pos_i,
  input  logic [OS_N-1:0]            mask_i,
  input  logic [CNT_W-1:0]           cmp2_i,
  output logic [OS_N-1:0][CNT_W-1:0] pos_q,
  output logic [OS_N-1:0]            mask_q,
  output logic [CNT_W-1:0]           cmp2_q,
  output logic [CNT_W-1:0]           prev_duty_q,
  output logic                       armed_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= '0;
      mask_q      <= '0;
      cmp2_q      <= '0;
      prev_duty_q <= '0;
      armed_q     <= 1'b0;
    end else if (upd_i) begin
      pos_q       <= pos_i;
      mask_q      <= mask_i;
      cmp2_q      <= cmp2_i;
      prev_duty_q <= duty_i;
      armed_q     <= 1'b1;
    end
  end

  AST_POS_HELD: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> ($stable(pos_q) && $stable(mask_q) && $stable(cmp2_q) && $stable(prev_duty_q))); // R8
  AST_OS_COUNT: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> ($countones(mask_q) == $past(os_i) + 1)); // R5
  AST_UNARMED_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> (mask_q == '0)); // R1
endmodule

// File: rtl/stg_pulse.sv
module stg_pulse
  import stg_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [OS_N-1:0][CNT_W-1:0] pos_i,
  input  logic [OS_N-1:0]            mask_i,
  input  logic [CNT_W-1:0]           cmp2_i,
  input  logic                       armed_i,
  input  logic                       t1_en_i,
  input  logic                       t2_en_i,
  output logic                       trig1_o,
  output logic                       trig2_o
);
  logic [OS_N-1:0] hit;

  for (genvar k = 0; k < OS_N; k++) begin : g_cmp
    assign hit[k] = mask_i[k] && (cnt_i == pos_i[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig1_o <= 1'b0;
      trig2_o <= 1'b0;
    end else begin
      trig1_o <= t1_en_i && (|hit);
      trig2_o <= t2_en_i && armed_i && (cnt_i == cmp2_i);
    end
  end

  AST_T1_GATED: assert property (@(posedge clk) disable iff (rst)
    !t1_en_i |=> !trig1_o); // R10
  AST_T2_GATED: assert property (@(posedge clk) disable iff (rst)
    !t2_en_i |=> !trig2_o); // R10
  AST_T1_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    !armed_i |=> !trig1_o); // R1
  AST_T1_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> !trig1_o); // R9
endmodule

// File: rtl/sample_trig_gen.sv
module sample_trig_gen
  import stg_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int OFS_W = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    upd_i,
  input  logic [CNT_W-1:0]        ev1_i,
  input  logic [CNT_W-1:0]        duty_i,
  input  logic signed [OFS_W-1:0] adapt_ofs_i,
  input  logic signed [OFS_W-1:0] fixed_ofs_i,
  input  logic [CNT_W-1:0]        prog_trig_i,
  input  logic [CNT_W-1:0]        trig2_cmp_i,
  input  logic                    ctl_we_i,
  input  logic [5:0]              ctl_wdata_i,
  output logic                    trig1_o,
  output logic                    trig2_o
);
  ctl_t                       ctl;
  logic [OS_N-1:0][CNT_W-1:0] pos_d, pos_q;
  logic [OS_N-1:0]            mask_d, mask_q;
  logic [CNT_W-1:0]           cmp2_q, prev_duty_q;
  logic                       armed_q;

  stg_ctl_reg i_ctl (
    .clk(clk), .rst(rst), .we_i(ctl_we_i), .wdata_i(ctl_wdata_i), .ctl_o(ctl)
  );

  stg_pos_calc #(.CNT_W(CNT_W), .OFS_W(OFS_W)) i_calc (
    .clk(clk), .rst(rst), .mode_i(ctl.mode), .os_i(ctl.os),
    .ev1_i(ev1_i), .duty_i(duty_i), .prev_duty_i(prev_duty_q),
    .adapt_ofs_i(adapt_ofs_i), .fixed_ofs_i(fixed_ofs_i), .prog_i(prog_trig_i),
    .pos_o(pos_d), .mask_o(mask_d)
  );

  stg_pos_latch #(.CNT_W(CNT_W)) i_latch (
    .clk(clk), .rst(rst), .upd_i(upd_i), .duty_i(duty_i), .os_i(ctl.os),
    .pos_i(pos_d), .mask_i(mask_d), .cmp2_i(trig2_cmp_i),
    .pos_q(pos_q), .mask_q(mask_q), .cmp2_q(cmp2_q),
    .prev_duty_q(prev_duty_q), .armed_q(armed_q)
  );

  stg_pulse #(.CNT_W(CNT_W)) i_pulse (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .pos_i(pos_q), .mask_i(mask_q),
    .cmp2_i(cmp2_q), .armed_i(armed_q), .t1_en_i(ctl.t1_en), .t2_en_i(ctl.t2_en),
    .trig1_o(trig1_o), .trig2_o(trig2_o)
  );
endmodule

// File: tb/test_sample_trig_gen.sv
module test_sample_trig_gen;
  localparam int CNT_W = 14;
  localparam int OFS_W = 14;
  localparam int TOP   = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [CNT_W-1:0] cnt = '0, ev1 = '0, duty = '0, prog = '0, cmp2 = '0;
  logic signed [OFS_W-1:0] aofs = '0, fofs = '0;
  logic upd = 1'b0, ctl_we = 1'b0;
  logic [5:0] ctl_wd = '0;
  logic trig1, trig2;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sample_trig_gen #(.CNT_W(CNT_W), .OFS_W(OFS_W)) i_sample_trig_gen (
    .clk(clk), .rst(rst), .cnt_i(cnt), .upd_i(upd), .ev1_i(ev1), .duty_i(duty),
    .adapt_ofs_i(aofs), .fixed_ofs_i(fofs), .prog_trig_i(prog), .trig2_cmp_i(cmp2),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd), .trig1_o(trig1), .trig2_o(trig2)
  );

  // mode, os, ev1, dutyA, dutyB, aofs, fofs, prog, expected base, expected pulse count
  localparam int NV = 10;
  localparam int VEC [NV][10] = '{
    '{0, 0,   0,  0,   0,   0,   0, 300, 300, 1},  // R2
    '{0, 1,   0,  0,   0,   0,   0, 400, 400, 2},  // R5
    '{0, 3,   0,  0,   0,   0,   0, 800, 800, 4},  // R5
    '{1, 0, 100, 50, 200,  10, -20, 900, 210, 1},  // R3
    '{2, 0, 100, 50, 200,  10, -20, 900, 135, 1},  // R4
    '{3, 0, 100, 50, 200,  10, -20, 900, 180, 1},  // R3
    '{1, 2,  50,  0, 300,   0,   0, 600, 200, 3},  // R3 R5
    '{0, 3,   0,  0,   0,   0,   0,   7,   7, 4},  // R5
    '{1, 1,   0,  0, 400,   0,   0, 400, 200, 1},  // R6
    '{1, 0,  10,  0,   0, -50,   0, 900,   0, 1}   // R7
  };

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctl(bit t1, bit t2, int mode, int os);
    @(negedge clk);
    ctl_wd = {t1, t2, 2'(mode), 2'(os)};
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic do_update(int e1, int d, int ao, int fo, int p, int c2);
    @(negedge clk);
    ev1 = CNT_W'(e1); duty = CNT_W'(d); aofs = OFS_W'(ao); fofs = OFS_W'(fo);
    prog = CNT_W'(p); cmp2 = CNT_W'(c2); upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  // Drives cnt from lo to hi; output in the cycle after each count is compared (R9).
  task automatic sweep(int lo, int hi, int e[4], bit [3:0] em, int t2p, bit t2x,
                       output int mis, output int n1, output int n2);
    mis = 0; n1 = 0; n2 = 0;
    for (int c = lo; c <= hi + 1; c++) begin
      @(negedge clk);
      if (c > lo) begin
        int p;
        bit x1;
        p = c - 1;
        x1 = 0;
        for (int k = 0; k < 4; k++) if (em[k] && e[k] == p) x1 = 1;
        if (trig1) n1++;
        if (trig2) n2++;
        if (trig1 !== x1) mis++;
        if (trig2 !== (t2x && p == t2p)) mis++;
      end
      if (c <= hi) cnt = CNT_W'(c);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int e[4];
    int mis, n1, n2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs low after reset, nothing fires before the first update
    check(trig1 === 1'b0 && trig2 === 1'b0, "R1 reset outputs", int'(trig1) + int'(trig2), 0);
    e = '{0, 0, 0, 0};
    sweep(0, 1023, e, 4'b0000, 0, 0, mis, n1, n2);
    check(mis == 0 && n1 == 0 && n2 == 0, "R1 no pulse before update", n1 + n2, 0);
    // R1: default control = t1 enabled, t2 disabled, mode 00, os 00
    do_update(0, 0, 0, 0, 250, 250);
    e = '{250, 0, 0, 0};
    sweep(0, 1023, e, 4'b0001, 250, 0, mis, n1, n2);
    check(mis == 0 && n1 == 1 && n2 == 0, "R1 reset control defaults", mis, 0);

    // Vector table: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      bit [3:0] em;
      write_ctl(1, 0, VEC[v][0], VEC[v][1]);
      do_update(VEC[v][2], VEC[v][3], VEC[v][5], VEC[v][6], VEC[v][7], 0);
      do_update(VEC[v][2], VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7], 0);
      e[0] = VEC[v][8];
      for (int k = 1; k < 4; k++) e[k] = VEC[v][7] >> k;
      for (int k = 0; k < 4; k++) em[k] = (k <= VEC[v][1]);
      sweep(0, 1023, e, em, 0, 0, mis, n1, n2);
      check(mis == 0, $sformatf("R2/R3/R4/R5/R7/R9 vector %0d mismatches", v), mis, 0);
      check(n1 == VEC[v][9], $sformatf("R5 R6 vector %0d pulse count", v), n1, VEC[v][9]);
    end

    // R7: saturation at the top of the counter
    write_ctl(1, 0, 1, 0);
    do_update(16000, 2000, 500, 0, 0, 0);
    e = '{TOP, 0, 0, 0};
    sweep(TOP - 13, TOP, e, 4'b0001, 0, 0, mis, n1, n2);
    check(mis == 0 && n1 == 1, "R7 saturate to max", n1, 1);

    // R8: a new programmed value without an update event has no effect
    write_ctl(1, 0, 0, 0);
    do_update(0, 0, 0, 0, 300, 0);
    @(negedge clk);
    prog = CNT_W'(700);
    e = '{300, 0, 0, 0};
    sweep(0, 1023, e, 4'b0001, 0, 0, mis, n1, n2);
    check(mis == 0 && n1 == 1, "R8 position held until update", mis, 0);

    // R10: trigger 1 disabled suppresses pulses at a valid position
    write_ctl(0, 0, 0, 0);
    sweep(0, 1023, e, 4'b0000, 0, 0, mis, n1, n2);
    check(n1 == 0, "R10 trig1 disabled", n1, 0);

    // R11: trigger 2 compare with latched value
    write_ctl(0, 1, 0, 0);
    do_update(0, 0, 0, 0, 300, 500);
    @(negedge clk);
    cmp2 = CNT_W'(900);
    sweep(0, 1023, e, 4'b0000, 500, 1, mis, n1, n2);
    check(mis == 0 && n2 == 1, "R11 trig2 single pulse at latched compare", n2, 1);
    check(n1 == 0, "R10 trig1 still disabled", n1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule